// File: doc/BRIEF.md
# ATA Single-Sector LBA Transfer Sequencer

This block drives an ATA device wired in 8-bit mode and moves one 256-byte sector per request, addressed by a 28-bit logical block number. A host presents the block number, chooses read or write, and pulses `start`. The sequencer first waits for the device to be idle and ready. It then programs the address and count registers and issues the command. It waits for the data request, streams the bytes through a byte-wide valid/ready channel, and waits for the device to settle. It then raises `done` for one clock, together with an error flag.

Every device register access goes through a separate register-cycle engine. The engine asserts chip select, drives a read or write strobe for a fixed number of clocks, and captures read data. Each status poll has a cycle-count limit, so a device that never becomes ready ends the operation with an error and cannot hang it. When reset is released, the block runs an initialize sequence of its own. It holds the device reset low, clears the stored address, and writes the drive-parameter command.

Top module: `ata_sector_seq`

## Requirements
- R1: After `rst_n` is released, `dev_rst_n` stays low for `RST_CYC` clocks. The block then writes 0x91 to register 7 as its only device write, pulses `done`, and leaves `error` at 0. While `dev_rst_n` is low, `dev_cs_n` stays high.
- R2: After `start`, status (register 7) is read until bit 7 reads 0. It is then read until bit 6 reads 1. Only after that does any address register get written.
- R3: The address is written as `lba[7:0]` to register 3, then `lba[15:8]` to register 4, then `lba[23:16]` to register 5. Register 6 is written next with the value 0xE0 OR `lba[27:24]`.
- R4: After register 6, the value 1 is written to register 2. Register 7 is written next with 0x20 when `write` was 0, or with 0x30 when `write` was 1.
- R5: After a read command, status is polled until bit 6 is 1 and then until bit 3 is 1. After a write command, status is polled until bit 7 is 0 and then until bit 3 is 1. The data phase starts only after this.
- R6: The data phase makes exactly 256 accesses to register 0. On a read, the bytes reach `m_data` in the order they were read. On a write, the bytes accepted on `s_data` are written in the order they were accepted.
- R7: In a read, a byte stays on `m_data`, with `m_valid` high, until `m_ready` takes it. No further device read starts while a byte is waiting. In a write, a device write starts only for a byte accepted with `s_valid` and `s_ready` both high.
- R8: After the data phase, status is polled until bit 7 is 0 and then until bit 6 is 1. After a write, `error` takes bit 0 of that final status read. After a read, `error` stays 0.
- R9: If one polling step goes on for more than `POLL_LIMIT` clocks, the operation ends. `error` is set, `done` pulses, no further register is written, and the next `start` is accepted.
- R10: `done` is high for exactly one clock per operation. `error` keeps its value until the next accepted `start`, which clears it.
- R11: A `start` that arrives while an operation is in progress is ignored. The running operation keeps its address and direction.
- R12: In a register cycle, `dev_cs_n` is low whenever `dev_rd_n` or `dev_wr_n` is low. The two strobes are never low together. `dev_dout` stays stable while a write cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a one-sector operation (taken in idle only) |
| write | input | 1 | 1 = write sector, 0 = read sector |
| lba | input | 28 | Logical block number |
| done | output | 1 | One-clock completion pulse |
| error | output | 1 | Error flag of the last operation |
| m_data | output | 8 | Read byte to host |
| m_valid | output | 1 | Read byte valid |
| m_ready | input | 1 | Host accepts read byte |
| s_data | input | 8 | Write byte from host |
| s_valid | input | 1 | Write byte valid |
| s_ready | output | 1 | Sequencer accepts write byte |
| dev_addr | output | 3 | Device register select |
| dev_cs_n | output | 1 | Device chip select, active low |
| dev_rd_n | output | 1 | Device read strobe, active low |
| dev_wr_n | output | 1 | Device write strobe, active low |
| dev_rst_n | output | 1 | Device reset, active low |
| dev_dout | output | 8 | Data driven to device |
| dev_doe | output | 1 | Output enable for `dev_dout` |
| dev_din | input | 8 | Data from device |

## Verification
The bench builds the block with `POLL_LIMIT` = 64 and `RST_CYC` = 8, leaving `STROBE_CYC` and the sector size at their defaults. With these values the reset pulse can be counted to the clock. A status register that stays busy runs into the timeout after about thirteen polls. Scripted status sequences show the order in which the polls are made, because the number of status reads before the first address write, before the first data access and before `done` is fixed.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam logic [2:0] REG_DATA    = 3'd0;
  localparam logic [2:0] REG_COUNT   = 3'd2;
  localparam logic [2:0] REG_LBA_LO  = 3'd3;
  localparam logic [2:0] REG_LBA_MID = 3'd4;
  localparam logic [2:0] REG_LBA_HI  = 3'd5;
  localparam logic [2:0] REG_HEAD    = 3'd6;
  localparam logic [2:0] REG_CMD     = 3'd7;

  localparam logic [7:0] CMD_RD_SECT = 8'h20;
  localparam logic [7:0] CMD_WR_SECT = 8'h30;
  localparam logic [7:0] CMD_INIT    = 8'h91;

  localparam int STB_BUSY = 7;
  localparam int STB_RDY  = 6;
  localparam int STB_DRQ  = 3;
  localparam int STB_ERR  = 0;

  typedef enum logic [4:0] {
    SQ_IDLE, SQ_RESET, SQ_INIT_CMD, SQ_PRE_BSY, SQ_PRE_RDY,
    SQ_LBA_LO, SQ_LBA_MID, SQ_LBA_HI, SQ_HEAD, SQ_COUNT, SQ_CMD,
    SQ_CMD_WAIT, SQ_DRQ, SQ_DATA, SQ_END_BSY, SQ_END_RDY, SQ_FIN
  } seq_state_e;

  // Head/device byte in LBA mode, drive 0: fixed ones in 7 and 5, LBA flag in 6.
  function automatic logic [7:0] head_byte(input logic [3:0] top);
    return {3'b111, 1'b0, top};
  endfunction

  function automatic logic is_poll(input seq_state_e st);
    return (st == SQ_PRE_BSY) || (st == SQ_PRE_RDY) || (st == SQ_CMD_WAIT) ||
           (st == SQ_DRQ) || (st == SQ_END_BSY) || (st == SQ_END_RDY);
  endfunction

  function automatic logic poll_met(input seq_state_e st, input logic is_wr,
                                    input logic [7:0] stat);
    case (st)
      SQ_PRE_BSY, SQ_END_BSY: return !stat[STB_BUSY];
      SQ_PRE_RDY, SQ_END_RDY: return stat[STB_RDY];
      SQ_CMD_WAIT:            return is_wr ? !stat[STB_BUSY] : stat[STB_RDY];
      SQ_DRQ:                 return stat[STB_DRQ];
      default:                return 1'b0;
    endcase
  endfunction

  function automatic seq_state_e poll_next(input seq_state_e st);
    case (st)
      SQ_PRE_BSY:  return SQ_PRE_RDY;
      SQ_PRE_RDY:  return SQ_LBA_LO;
      SQ_CMD_WAIT: return SQ_DRQ;
      SQ_DRQ:      return SQ_DATA;
      SQ_END_BSY:  return SQ_END_RDY;
      default:     return SQ_FIN;
    endcase
  endfunction
endpackage

// File: rtl/ata_reg_port.sv
module ata_reg_port #(
  parameter int STROBE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic       ack,
  output logic [7:0] rdata,
  output logic [2:0] dev_addr,
  output logic       dev_cs_n,
  output logic       dev_rd_n,
  output logic       dev_wr_n,
  output logic [7:0] dev_dout,
  output logic       dev_doe,
  input  logic [7:0] dev_din
);
  localparam int SCW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_STRB, E_HOLD} eng_state_e;
  eng_state_e es;
  logic [SCW-1:0] sc;
  logic           we_q;
  logic [2:0]     a_q;
  logic [7:0]     d_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es <= E_IDLE; sc <= '0; we_q <= 1'b0; a_q <= '0; d_q <= '0; rd_q <= '0;
    end else begin
      unique case (es)
        E_IDLE:  if (req) begin es <= E_SETUP; a_q <= addr; d_q <= wdata; we_q <= we; end
        E_SETUP: begin es <= E_STRB; sc <= '0; end
        E_STRB:  if (sc == SCW'(STROBE_CYC - 1)) begin es <= E_HOLD; rd_q <= dev_din; end
                 else sc <= sc + 1'b1;
        default: es <= E_IDLE;
      endcase
    end
  end

  assign ack      = (es == E_HOLD);
  assign rdata    = rd_q;
  assign dev_addr = a_q;
  assign dev_cs_n = (es == E_IDLE);
  assign dev_rd_n = !((es == E_STRB) && !we_q);
  assign dev_wr_n = !((es == E_STRB) && we_q);
  assign dev_dout = d_q;
  assign dev_doe  = we_q && (es != E_IDLE);

  // R12
  strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n || !dev_wr_n) |-> !dev_cs_n);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rd_n && !dev_wr_n));
  // R12
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_doe && !dev_cs_n && $past(!dev_cs_n)) |-> $stable(dev_dout));
  // R12
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> dev_cs_n);
endmodule

// File: rtl/ata_seq_fsm.sv
module ata_seq_fsm
  import ata_seq_pkg::*;
#(
  parameter int POLL_LIMIT   = 100000,
  parameter int RST_CYC      = 2000,
  parameter int SECTOR_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        write,
  input  logic [27:0] lba,
  output logic        done,
  output logic        error,
  output logic [7:0]  m_data,
  output logic        m_valid,
  input  logic        m_ready,
  input  logic [7:0]  s_data,
  input  logic        s_valid,
  output logic        s_ready,
  output logic        eng_req,
  output logic        eng_we,
  output logic [2:0]  eng_addr,
  output logic [7:0]  eng_wdata,
  input  logic        eng_ack,
  input  logic [7:0]  eng_rdata,
  output logic        dev_rst_n
);
  localparam int TMAX = (POLL_LIMIT > RST_CYC) ? POLL_LIMIT : RST_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(SECTOR_BYTES + 1);

  seq_state_e st, st_nx;
  logic [TW-1:0] timer;
  logic [BW-1:0] byte_cnt;
  logic [27:0]   lba_q;
  logic          wr_q, err_q, issued, mv_q;
  logic [7:0]    md_q;

  // named events for the checks
  logic poll_state, poll_hit, poll_expire, data_last, sect_full;
  assign poll_state  = is_poll(st);
  assign poll_hit    = poll_state && eng_ack && poll_met(st, wr_q, eng_rdata);
  assign poll_expire = poll_state && eng_ack && !poll_met(st, wr_q, eng_rdata) &&
                       (timer >= TW'(POLL_LIMIT));
  assign sect_full   = (byte_cnt == BW'(SECTOR_BYTES));
  assign data_last   = (st == SQ_DATA) &&
                       (wr_q ? (eng_ack && byte_cnt == BW'(SECTOR_BYTES - 1))
                             : (mv_q && m_ready && sect_full));

  always_comb begin
    st_nx = st;
    case (st)
      SQ_IDLE:     if (start) st_nx = SQ_PRE_BSY;
      SQ_RESET:    if (timer == TW'(RST_CYC - 1)) st_nx = SQ_INIT_CMD;
      SQ_INIT_CMD: if (eng_ack) st_nx = SQ_FIN;
      SQ_LBA_LO:   if (eng_ack) st_nx = SQ_LBA_MID;
      SQ_LBA_MID:  if (eng_ack) st_nx = SQ_LBA_HI;
      SQ_LBA_HI:   if (eng_ack) st_nx = SQ_HEAD;
      SQ_HEAD:     if (eng_ack) st_nx = SQ_COUNT;
      SQ_COUNT:    if (eng_ack) st_nx = SQ_CMD;
      SQ_CMD:      if (eng_ack) st_nx = SQ_CMD_WAIT;
      SQ_DATA:     if (data_last) st_nx = SQ_END_BSY;
      SQ_FIN:      st_nx = SQ_IDLE;
      default: begin
        if (poll_expire)   st_nx = SQ_FIN;
        else if (poll_hit) st_nx = poll_next(st);
      end
    endcase
  end

  always_comb begin
    eng_req = 1'b0; eng_we = 1'b1; eng_addr = REG_CMD; eng_wdata = '0;
    s_ready = 1'b0;
    case (st)
      SQ_INIT_CMD: begin eng_req = !issued; eng_wdata = CMD_INIT; end
      SQ_LBA_LO:   begin eng_req = !issued; eng_addr = REG_LBA_LO;  eng_wdata = lba_q[7:0]; end
      SQ_LBA_MID:  begin eng_req = !issued; eng_addr = REG_LBA_MID; eng_wdata = lba_q[15:8]; end
      SQ_LBA_HI:   begin eng_req = !issued; eng_addr = REG_LBA_HI;  eng_wdata = lba_q[23:16]; end
      SQ_HEAD:     begin eng_req = !issued; eng_addr = REG_HEAD;    eng_wdata = head_byte(lba_q[27:24]); end
      SQ_COUNT:    begin eng_req = !issued; eng_addr = REG_COUNT;   eng_wdata = 8'd1; end
      SQ_CMD:      begin eng_req = !issued; eng_wdata = wr_q ? CMD_WR_SECT : CMD_RD_SECT; end
      SQ_DATA: begin
        eng_addr = REG_DATA;
        if (wr_q) begin
          s_ready   = !issued && !sect_full;
          eng_req   = s_ready && s_valid;
          eng_wdata = s_data;
        end else begin
          eng_we  = 1'b0;
          eng_req = !issued && !mv_q && !sect_full;
        end
      end
      default: if (poll_state) begin eng_req = !issued; eng_we = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_RESET; timer <= '0; byte_cnt <= '0; lba_q <= '0; wr_q <= 1'b0;
      err_q <= 1'b0; issued <= 1'b0; mv_q <= 1'b0; md_q <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st) timer <= '0;
      else if ((poll_state || st == SQ_RESET) && timer != TW'(TMAX)) timer <= timer + 1'b1;
      if (eng_ack) issued <= 1'b0;
      else if (eng_req) issued <= 1'b1;
      if (st == SQ_RESET) lba_q <= '0;
      if (st == SQ_IDLE && start) begin
        lba_q <= lba; wr_q <= write; err_q <= 1'b0; byte_cnt <= '0;
      end
      if (poll_expire) err_q <= 1'b1;
      else if (st == SQ_END_RDY && poll_hit && wr_q) err_q <= eng_rdata[STB_ERR];
      if (st == SQ_DATA && eng_ack) byte_cnt <= byte_cnt + 1'b1;
      if (st == SQ_DATA && !wr_q && eng_ack) begin
        md_q <= eng_rdata; mv_q <= 1'b1;
      end else if (mv_q && m_ready) mv_q <= 1'b0;
    end
  end

  assign done      = (st == SQ_FIN);
  assign error     = err_q;
  assign m_data    = md_q;
  assign m_valid   = mv_q;
  assign dev_rst_n = (st != SQ_RESET);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  // R9
  expire_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expire |=> (done && error));
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != SQ_IDLE && st != SQ_RESET) |=> ($stable(lba_q) && $stable(wr_q)));
endmodule

// File: rtl/ata_sector_seq.sv
module ata_sector_seq #(
  parameter int STROBE_CYC   = 2,
  parameter int POLL_LIMIT   = 100000,
  parameter int RST_CYC      = 2000,
  parameter int SECTOR_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        write,
  input  logic [27:0] lba,
  output logic        done,
  output logic        error,
  output logic [7:0]  m_data,
  output logic        m_valid,
  input  logic        m_ready,
  input  logic [7:0]  s_data,
  input  logic        s_valid,
  output logic        s_ready,
  output logic [2:0]  dev_addr,
  output logic        dev_cs_n,
  output logic        dev_rd_n,
  output logic        dev_wr_n,
  output logic        dev_rst_n,
  output logic [7:0]  dev_dout,
  output logic        dev_doe,
  input  logic [7:0]  dev_din
);
  logic       eng_req, eng_we, eng_ack;
  logic [2:0] eng_addr;
  logic [7:0] eng_wdata, eng_rdata;

  ata_seq_fsm #(
    .POLL_LIMIT(POLL_LIMIT), .RST_CYC(RST_CYC), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .write(write), .lba(lba),
    .done(done), .error(error), .m_data(m_data), .m_valid(m_valid),
    .m_ready(m_ready), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .dev_rst_n(dev_rst_n)
  );

  ata_reg_port #(.STROBE_CYC(STROBE_CYC)) u_port (
    .clk(clk), .rst_n(rst_n), .req(eng_req), .we(eng_we), .addr(eng_addr),
    .wdata(eng_wdata), .ack(eng_ack), .rdata(eng_rdata),
    .dev_addr(dev_addr), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n),
    .dev_wr_n(dev_wr_n), .dev_dout(dev_dout), .dev_doe(dev_doe),
    .dev_din(dev_din)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |-> dev_cs_n);
endmodule

// File: tb/ata_sector_seq_bench.sv
module ata_sector_seq_bench;
  localparam int POLL_LIMIT = 64;
  localparam int RST_CYC    = 8;
  localparam int NB         = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, write = 1'b0, m_ready = 1'b0, s_valid = 1'b0;
  logic [27:0] lba = '0;
  logic [7:0]  s_data = '0, m_data, dev_dout, dev_din;
  logic done, error, m_valid, s_ready, dev_cs_n, dev_rd_n, dev_wr_n, dev_rst_n, dev_doe;
  logic [2:0] dev_addr;

  ata_sector_seq #(.STROBE_CYC(2), .POLL_LIMIT(POLL_LIMIT), .RST_CYC(RST_CYC),
                   .SECTOR_BYTES(NB)) u_ata_sector_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .write(write), .lba(lba),
    .done(done), .error(error), .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .dev_addr(dev_addr),
    .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_rst_n(dev_rst_n), .dev_dout(dev_dout), .dev_doe(dev_doe), .dev_din(dev_din)
  );

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] script [16];
  int   script_len = 0, script_pos = 0;
  logic [7:0] idle_status = 8'h50;
  int   data_idx = 0;
  logic [7:0] cur_status;
  assign cur_status = (script_pos < script_len) ? script[script_pos] : idle_status;
  assign dev_din = (dev_addr == 3'd7) ? cur_status : 8'((data_idx * 13 + 5) & 255);

  logic [10:0] exp_wr [$];
  logic [7:0]  exp_rd [$];
  int stat_reads = 0, data_reads = 0, host_taken = 0, bp_viol = 0;
  int stat_at_lba = -1, stat_at_data = -1, done_cnt = 0, done_wide = 0, cyc = 0;
  bit lba_seen = 0, data_seen = 0, hold_mode = 0;
  logic prev_rd_n = 1, prev_wr_n = 1, prev_mv = 0, prev_mr = 0, prev_done = 0;
  logic [7:0] prev_md = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!prev_rd_n && dev_rd_n) begin
        if (dev_addr == 3'd7) begin stat_reads++; script_pos++; end
        else if (dev_addr == 3'd0) begin
          if (!data_seen) begin data_seen = 1; stat_at_data = stat_reads; end
          data_reads++; data_idx++;
        end
      end
      if (!prev_wr_n && dev_wr_n) begin
        string t;
        t = (dev_addr == 3'd0) ? "R6" : ((dev_addr == 3'd2 || dev_addr == 3'd7) ? "R4" : "R3");
        if (dev_addr == 3'd3 && !lba_seen) begin lba_seen = 1; stat_at_lba = stat_reads; end
        if (dev_addr == 3'd0 && !data_seen) begin data_seen = 1; stat_at_data = stat_reads; end
        if (exp_wr.size() == 0) chk(0, t, "unexpected device write", {dev_addr, dev_dout}, 0);
        else begin
          logic [10:0] e;
          e = exp_wr.pop_front();
          chk({dev_addr, dev_dout} == e, t, "device write", {dev_addr, dev_dout}, e);
        end
      end
      if (m_valid && m_ready) begin
        if (exp_rd.size() == 0) chk(0, "R6", "unexpected host byte", m_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rd.pop_front();
          chk(m_data == e, "R6", "host read byte", m_data, e);
        end
        host_taken++;
      end
      if (data_reads - host_taken > 1) bp_viol++;
      if (prev_mv && !prev_mr && (!m_valid || m_data != prev_md)) bp_viol++;
      if (done) done_cnt++;
      if (done && prev_done) done_wide++;
    end
    prev_rd_n = dev_rd_n; prev_wr_n = dev_wr_n; prev_mv = m_valid;
    prev_mr = m_ready; prev_md = m_data; prev_done = done;
  end

  // host read-side readiness
  initial forever begin
    @(posedge clk); #2;
    m_ready = hold_mode ? ((cyc % 5) != 2 && (cyc % 7) != 0) : 1'b1;
  end

  // ---------------- driver ----------------
  task automatic push_st(input logic [7:0] v);
    script[script_len] = v; script_len++;
  endtask

  task automatic new_op();
    script_len = 0; script_pos = 0; data_idx = 0; stat_reads = 0; data_reads = 0;
    host_taken = 0; bp_viol = 0; lba_seen = 0; data_seen = 0;
    stat_at_lba = -1; stat_at_data = -1; done_cnt = 0; done_wide = 0;
  endtask

  task automatic expect_cmd(input bit wr, input logic [27:0] a);
    exp_wr.push_back({3'd3, a[7:0]});
    exp_wr.push_back({3'd4, a[15:8]});
    exp_wr.push_back({3'd5, a[23:16]});
    exp_wr.push_back({3'd6, 8'hE0 | {4'h0, a[27:24]}});
    exp_wr.push_back({3'd2, 8'd1});
    exp_wr.push_back({3'd7, wr ? 8'h30 : 8'h20});
    for (int k = 0; k < NB; k++) begin
      if (wr) exp_wr.push_back({3'd0, 8'((k * 7 + 3) & 255)});
      else exp_rd.push_back(8'((k * 13 + 5) & 255));
    end
  endtask

  task automatic pulse_start(input bit wr, input logic [27:0] a);
    @(posedge clk); #2; start = 1; write = wr; lba = a;
    @(posedge clk); #2; start = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);
  endtask

  task automatic stream_write();
    for (int k = 0; k < NB; k++) begin
      if (k % 9 == 4) begin s_valid = 0; @(posedge clk); #2; end
      s_valid = 1; s_data = 8'((k * 7 + 3) & 255);
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #2;
    end
    s_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int rst_low, t0;
    exp_wr.push_back({3'd7, 8'h91});
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(dev_rst_n == 0, "R1", "dev_rst_n in reset", dev_rst_n, 0);
    chk(dev_cs_n == 1 && done == 0 && m_valid == 0 && s_ready == 0, "R1",
        "idle outputs in reset", {dev_cs_n, done, m_valid, s_ready}, 4'b1000);
    // count from the negedge at which reset is released
    rst_low = 0;
    rst_n = 1;
    while (!dev_rst_n) begin rst_low++; @(negedge clk); end
    chk(rst_low == RST_CYC, "R1", "device reset width", rst_low, RST_CYC);
    wait_done();
    chk(error == 0, "R1", "error after init", error, 0);
    chk(exp_wr.size() == 0, "R1", "init command written", exp_wr.size(), 0);
    chk(done_cnt == 1, "R1", "init done pulses", done_cnt, 1);

    // read with backpressure and a stray start in the data phase
    new_op(); hold_mode = 1;
    push_st(8'h80); push_st(8'h80); push_st(8'h00); push_st(8'h40);
    push_st(8'h80); push_st(8'h40); push_st(8'h40); push_st(8'h48);
    push_st(8'h80); push_st(8'h40);
    expect_cmd(0, 28'h9ABCDEF);
    pulse_start(0, 28'h9ABCDEF);
    repeat (200) @(posedge clk);
    pulse_start(1, 28'h1234567);  // R11: must be ignored
    wait_done();
    chk(stat_at_lba == 4, "R2", "status reads before address", stat_at_lba, 4);
    chk(stat_at_data == 8, "R5", "status reads before data (read)", stat_at_data, 8);
    chk(stat_reads == 11, "R8", "status reads at done (read)", stat_reads, 11);
    chk(error == 0, "R8", "error after read", error, 0);
    chk(host_taken == NB && exp_rd.size() == 0, "R6", "bytes to host", host_taken, NB);
    chk(data_reads == NB, "R6", "data register reads", data_reads, NB);
    chk(bp_viol == 0, "R7", "backpressure violations", bp_viol, 0);
    chk(exp_wr.size() == 0, "R3", "command writes consumed", exp_wr.size(), 0);
    chk(done_cnt == 1, "R11", "done pulses with stray start", done_cnt, 1);
    chk(done_wide == 0, "R10", "done width", done_wide, 0);

    // write with device error bit set at completion
    new_op(); hold_mode = 0;
    push_st(8'h50); push_st(8'h50);
    push_st(8'h80); push_st(8'h50); push_st(8'h50); push_st(8'h58);
    push_st(8'h50); push_st(8'h51);
    expect_cmd(1, 28'h0000102);
    pulse_start(1, 28'h0000102);
    stream_write();
    wait_done();
    chk(stat_at_lba == 2, "R2", "status reads before address (write)", stat_at_lba, 2);
    chk(stat_at_data == 6, "R5", "status reads before data (write)", stat_at_data, 6);
    chk(stat_reads == 8, "R8", "status reads at done (write)", stat_reads, 8);
    chk(error == 1, "R8", "error from status bit 0", error, 1);
    chk(exp_wr.size() == 0, "R6", "all write bytes reached device", exp_wr.size(), 0);
    repeat (30) @(negedge clk);
    chk(error == 1, "R10", "error held while idle", error, 1);

    // timeout: device stays busy
    new_op(); idle_status = 8'h80;
    pulse_start(0, 28'h0000005);
    @(negedge clk);
    chk(error == 0, "R10", "error cleared by start", error, 0);
    t0 = cyc;
    do @(negedge clk); while (!done);
    chk(cyc - t0 >= POLL_LIMIT, "R9", "timeout delay", cyc - t0, POLL_LIMIT);
    chk(error == 1, "R9", "error on timeout", error, 1);
    chk(lba_seen == 0, "R9", "no register write on timeout", lba_seen, 0);
    repeat (3) @(negedge clk);

    // recovery after timeout
    new_op(); idle_status = 8'h58;
    expect_cmd(0, 28'hFFFFFFF);
    pulse_start(0, 28'hFFFFFFF);
    wait_done();
    chk(error == 0, "R9", "operation after timeout", error, 0);
    chk(host_taken == NB && exp_wr.size() == 0, "R9", "bytes after recovery", host_taken, NB);
    chk(stat_at_lba == 2, "R2", "status reads, idle device", stat_at_lba, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule